// File: doc/BRIEF.md
# Vector Instruction Issue Control

This block sits between a queue of fixed-format vector instruction words and three execution subunits: add, multiply and address-mask. Each cycle it looks at the instruction at the head of the queue. It checks three things: whether the target subunit is free, whether a divide is still running, and whether any vector register the instruction names will be touched next cycle by work already in flight. If all three checks pass, it accepts the instruction and sends it to the chosen subunit one cycle later. If any check fails, the instruction stays at the head of the queue and is tried again in the next cycle.

The subunits report the register addresses they will use in the next cycle. They give these on a flat bus of slots, and each slot has its own valid bit. The block compares these addresses against the destination and source registers of the candidate instruction. Only the registers that the instruction marks as used take part in the comparison.

The block also owns the vector length register. A write to it takes effect at once. Every issued instruction carries its own copy of the length, so later writes never reach work that has already left. The scalar operand that comes with the instruction is forwarded unchanged.

Top module: `vec_issue_ctrl`

## Requirements
- R1: The head instruction is not accepted while any valid activity slot holds an address equal to a register the instruction uses. The registers are the destination in control bits 3:0, source A in bits 7:4 and source B in bits 11:8. Each one takes part only when its use flag is set: bit 12 for the destination, bit 13 for source A and bit 14 for source B.
- R2: An instruction that is refused stays presented and is issued unchanged in a later cycle, once every blocking condition has cleared.
- R3: The subunit is chosen by word bits 44:43: 0 selects add, 1 multiply, 2 address-mask and 3 add. On `iss_valid`, bit 0 is add, bit 1 is multiply and bit 2 is address-mask. At most one bit is set in any cycle.
- R4: `in_ready` is high exactly in the cycles in which `in_valid` is high and no blocking condition holds. The issue pulse appears on `iss_valid` in the following cycle. In every other cycle `iss_valid` is zero.
- R5: `iss_vlen` holds the length value that was captured when the instruction was issued. It changes only when another instruction issues, whatever is written to the length register in between.
- R6: A length write takes effect in the cycle it is made. An instruction that issues in the same cycle as a write carries the newly written value.
- R7: After an instruction with word bit 45 set (a divide) issues, no instruction is accepted until the subunit that took the divide raises its done bit.
- R8: A subunit is busy from the cycle after it receives an instruction until a cycle in which its `unit_done` bit is high. No instruction is accepted for a busy subunit.
- R9: Activity slots whose valid bit is low, and candidate registers whose use flag is clear, never block issue.
- R10: After reset, `iss_valid` is zero and the length register holds VL_RESET (64 by default).
- R11: The issued opcode (word bits 39:32), the control-word type (bits 42:40), the 32-bit control word (bits 31:0), the divide flag and the scalar operand are forwarded unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Head instruction present |
| in_ready | output | 1 | Head instruction accepted this cycle |
| in_insn | input | 64 | Encoded instruction word |
| in_scalar | input | SCALAR_W | Scalar operand for the head instruction |
| act_addr | input | N_ACT*4 | Next-cycle register addresses of active work |
| act_vld | input | N_ACT | Valid bit per activity slot |
| unit_done | input | 3 | Subunit finished its instruction (add, mul, addr-mask) |
| vl_we | input | 1 | Write the vector length register |
| vl_wdata | input | VL_W | New vector length |
| iss_valid | output | 3 | One-hot issue pulse per subunit |
| iss_opcode | output | 8 | Issued opcode |
| iss_ctype | output | 3 | Issued control-word type |
| iss_ctrl | output | 32 | Issued control word |
| iss_scalar | output | SCALAR_W | Issued scalar operand |
| iss_vlen | output | VL_W | Vector length snapshot of the issued instruction |
| iss_div | output | 1 | Issued instruction is a divide |

## Verification
The assertions assume that `unit_done` is meaningful only for a subunit that is busy. A done bit from an idle subunit is ignored, so the assertions still hold when that bit is random. They also assume that the activity bus describes the next cycle only, and that the instruction is held stable while it is refused. The random stimulus follows these rules. It keeps a refused instruction on the input until it is accepted, and it picks new activity slots with sparse valid bits every cycle. Done bits are random, so both rare and immediate completion occur, and divides are drawn rarely so that blocking does not dominate the run.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NUM_UNITS = 3;
    localparam int UNIT_W    = 2;
    localparam int REG_W     = 4;

    localparam int F_UNIT_LO = 43;
    localparam int F_DIV     = 45;

    typedef enum logic [UNIT_W-1:0] {
        U_ADD = 2'd0,
        U_MUL = 2'd1,
        U_AMK = 2'd2,
        U_ALT = 2'd3
    } unit_code_e;

    typedef struct packed {
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] srca;
        logic [REG_W-1:0] srcb;
        logic             use_d;
        logic             use_a;
        logic             use_b;
    } regset_t;

    function automatic regset_t get_regs(input logic [31:0] cw);
        regset_t r;
        r.dst   = cw[3:0];
        r.srca  = cw[7:4];
        r.srcb  = cw[11:8];
        r.use_d = cw[12];
        r.use_a = cw[13];
        r.use_b = cw[14];
        return r;
    endfunction

    function automatic logic [UNIT_W-1:0] unit_index(input logic [UNIT_W-1:0] code);
        return (unit_code_e'(code) == U_ALT) ? UNIT_W'(U_ADD) : code;
    endfunction
endpackage

// File: rtl/vic_conflict.sv
module vic_conflict
    import vic_pkg::*;
#(
    parameter int N_ACT = 9
) (
    input  regset_t                need,
    input  logic [N_ACT*REG_W-1:0] act_addr,
    input  logic [N_ACT-1:0]       act_vld,
    output logic                   conflict
);
    logic [N_ACT-1:0] hit;

    for (genvar g = 0; g < N_ACT; g++) begin : g_slot
        logic [REG_W-1:0] slot;
        assign slot   = act_addr[g*REG_W +: REG_W];
        assign hit[g] = act_vld[g] &&
                        ((need.use_d && slot == need.dst)  ||
                         (need.use_a && slot == need.srca) ||
                         (need.use_b && slot == need.srcb));
    end

    assign conflict = |hit;
endmodule

// File: rtl/vic_unit_track.sv
module vic_unit_track
    import vic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_fire,
    input  logic [UNIT_W-1:0]    issue_unit,
    input  logic                 issue_div,
    input  logic [NUM_UNITS-1:0] unit_done,
    output logic [NUM_UNITS-1:0] unit_busy,
    output logic                 div_block
);
    typedef struct packed {
        logic [NUM_UNITS-1:0] busy;
        logic                 div;
        logic [UNIT_W-1:0]    div_unit;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        logic [NUM_UNITS-1:0] fin;
        trk_d = trk_q;
        fin   = unit_done & trk_q.busy;
        if (trk_q.div && fin[trk_q.div_unit]) begin
            trk_d.div = 1'b0;
        end
        trk_d.busy = trk_q.busy & ~fin;
        if (issue_fire) begin
            trk_d.busy[issue_unit] = 1'b1;
            if (issue_div) begin
                trk_d.div      = 1'b1;
                trk_d.div_unit = issue_unit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign unit_busy = trk_q.busy;
    assign div_block = trk_q.div;

    assert_no_busy_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |-> !trk_q.busy[issue_unit]);

    assert_busy_after_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_fire |=> trk_q.busy[$past(issue_unit)]);

    assert_div_holds_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.div |-> !issue_fire);
endmodule

// File: rtl/vic_vlen.sv
module vic_vlen #(
    parameter int VL_W     = 7,
    parameter int VL_RESET = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [VL_W-1:0] wdata,
    output logic [VL_W-1:0] cur
);
    logic [VL_W-1:0] vl_d, vl_q;

    always_comb begin
        vl_d = we ? wdata : vl_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q <= VL_W'(VL_RESET);
        end else begin
            vl_q <= vl_d;
        end
    end

    assign cur = vl_d;

    assert_vl_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (vl_q == $past(wdata)));
endmodule

// File: rtl/vec_issue_ctrl.sv
module vec_issue_ctrl
    import vic_pkg::*;
#(
    parameter int PORTS_PER_UNIT = 3,
    parameter int SCALAR_W       = 64,
    parameter int VL_W           = 7,
    parameter int VL_RESET       = 64,
    localparam int N_ACT         = NUM_UNITS * PORTS_PER_UNIT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [63:0]            in_insn,
    input  logic [SCALAR_W-1:0]    in_scalar,
    input  logic [N_ACT*REG_W-1:0] act_addr,
    input  logic [N_ACT-1:0]       act_vld,
    input  logic [NUM_UNITS-1:0]   unit_done,
    input  logic                   vl_we,
    input  logic [VL_W-1:0]        vl_wdata,
    output logic [NUM_UNITS-1:0]   iss_valid,
    output logic [7:0]             iss_opcode,
    output logic [2:0]             iss_ctype,
    output logic [31:0]            iss_ctrl,
    output logic [SCALAR_W-1:0]    iss_scalar,
    output logic [VL_W-1:0]        iss_vlen,
    output logic                   iss_div
);
    typedef struct packed {
        logic [NUM_UNITS-1:0] valid;
        logic [7:0]           opcode;
        logic [2:0]           ctype;
        logic [31:0]          ctrl;
        logic [SCALAR_W-1:0]  scalar;
        logic [VL_W-1:0]      vlen;
        logic                 div;
    } out_t;

    out_t out_d, out_q;

    logic                 conflict;
    logic [NUM_UNITS-1:0] unit_busy;
    logic                 div_block;
    logic [VL_W-1:0]      vl_now;
    logic [UNIT_W-1:0]    sel_unit;
    logic                 is_div;
    logic                 fire;
    regset_t              need;

    assign need     = get_regs(in_insn[31:0]);
    assign sel_unit = unit_index(in_insn[F_UNIT_LO +: UNIT_W]);
    assign is_div   = in_insn[F_DIV];

    vic_conflict #(.N_ACT(N_ACT)) u_conflict (
        .need     (need),
        .act_addr (act_addr),
        .act_vld  (act_vld),
        .conflict (conflict)
    );

    vic_unit_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_fire (fire),
        .issue_unit (sel_unit),
        .issue_div  (is_div),
        .unit_done  (unit_done),
        .unit_busy  (unit_busy),
        .div_block  (div_block)
    );

    vic_vlen #(.VL_W(VL_W), .VL_RESET(VL_RESET)) u_vlen (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (vl_we),
        .wdata (vl_wdata),
        .cur   (vl_now)
    );

    assign fire     = in_valid && !conflict && !unit_busy[sel_unit] && !div_block;
    assign in_ready = fire;

    always_comb begin
        out_d       = out_q;
        out_d.valid = '0;
        if (fire) begin
            out_d.valid  = NUM_UNITS'(1) << sel_unit;
            out_d.opcode = in_insn[39:32];
            out_d.ctype  = in_insn[42:40];
            out_d.ctrl   = in_insn[31:0];
            out_d.scalar = in_scalar;
            out_d.vlen   = vl_now;
            out_d.div    = is_div;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign iss_valid  = out_q.valid;
    assign iss_opcode = out_q.opcode;
    assign iss_ctype  = out_q.ctype;
    assign iss_ctrl   = out_q.ctrl;
    assign iss_scalar = out_q.scalar;
    assign iss_vlen   = out_q.vlen;
    assign iss_div    = out_q.div;

    assert_ready_clear_of_conflict_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !conflict);

    assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iss_valid));

    assert_pulse_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> (iss_valid != '0));

    assert_quiet_without_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> (iss_valid == '0));

    assert_vlen_snapshot_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(iss_vlen));
endmodule

// File: tb/vec_issue_ctrl_test.sv
module vec_issue_ctrl_test;
    localparam int NACT = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_insn = '0;
    logic [63:0] in_scalar = '0;
    logic [NACT*4-1:0] act_addr = '0;
    logic [NACT-1:0]   act_vld = '0;
    logic [2:0]  unit_done = '0;
    logic        vl_we = 1'b0;
    logic [6:0]  vl_wdata = '0;
    logic [2:0]  iss_valid;
    logic [7:0]  iss_opcode;
    logic [2:0]  iss_ctype;
    logic [31:0] iss_ctrl;
    logic [63:0] iss_scalar;
    logic [6:0]  iss_vlen;
    logic        iss_div;

    int checks = 0;
    int errors = 0;

    bit [2:0]  m_busy = '0;
    bit        m_div = 1'b0;
    int        m_div_u = 0;
    bit [6:0]  m_vl = 7'd64;
    bit [2:0]  e_valid = '0;
    bit [7:0]  e_op = '0;
    bit [2:0]  e_ct = '0;
    bit [31:0] e_ctrl = '0;
    bit [63:0] e_sc = '0;
    bit [6:0]  e_vl = '0;
    bit        e_div = 1'b0;
    bit        last_iss = 1'b0;

    always #10 clk = ~clk;

    vec_issue_ctrl uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_insn(in_insn), .in_scalar(in_scalar), .act_addr(act_addr),
        .act_vld(act_vld), .unit_done(unit_done), .vl_we(vl_we),
        .vl_wdata(vl_wdata), .iss_valid(iss_valid), .iss_opcode(iss_opcode),
        .iss_ctype(iss_ctype), .iss_ctrl(iss_ctrl), .iss_scalar(iss_scalar),
        .iss_vlen(iss_vlen), .iss_div(iss_div)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int uidx(input logic [63:0] w);
        return (w[44:43] == 2'd3) ? 0 : int'(w[44:43]);
    endfunction

    function automatic bit exp_conflict();
        for (int i = 0; i < NACT; i++) begin
            logic [3:0] s = act_addr[i*4 +: 4];
            if (act_vld[i] && ((in_insn[12] && s == in_insn[3:0]) ||
                               (in_insn[13] && s == in_insn[7:4]) ||
                               (in_insn[14] && s == in_insn[11:8])))
                return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic [63:0] mk(input int op, input int ct, input int unit,
                                       input bit dv, input int d, input int a,
                                       input int b, input int uses);
        logic [63:0] w = '0;
        w[39:32] = 8'(op);
        w[42:40] = 3'(ct);
        w[44:43] = 2'(unit);
        w[45]    = dv;
        w[3:0]   = 4'(d);
        w[7:4]   = 4'(a);
        w[11:8]  = 4'(b);
        w[14:12] = 3'(uses);
        w[31:15] = 17'h1a5c3;
        return w;
    endfunction

    task automatic tick();
        bit eiss, cf;
        bit [2:0] fin;
        bit [6:0] snap;
        int u;
        #2;
        cf = exp_conflict();
        u = uidx(in_insn);
        eiss = in_valid && !cf && !m_busy[u] && !m_div;
        if (in_valid && cf)            chk("R1 ready", in_ready, eiss);
        else if (in_valid && m_div)    chk("R7 ready", in_ready, eiss);
        else if (in_valid && m_busy[u]) chk("R8 ready", in_ready, eiss);
        else                           chk("R4 ready", in_ready, eiss);
        @(posedge clk);
        snap = vl_we ? vl_wdata : m_vl;
        if (vl_we) m_vl = vl_wdata;
        fin = unit_done & m_busy;
        if (m_div && fin[m_div_u]) m_div = 1'b0;
        m_busy = m_busy & ~fin;
        e_valid = '0;
        if (eiss) begin
            e_valid = 3'(1 << u);
            e_op = in_insn[39:32];
            e_ct = in_insn[42:40];
            e_ctrl = in_insn[31:0];
            e_sc = in_scalar;
            e_vl = snap;
            e_div = in_insn[45];
            m_busy[u] = 1'b1;
            if (in_insn[45]) begin
                m_div = 1'b1;
                m_div_u = u;
            end
        end
        last_iss = eiss;
        @(negedge clk);
        chk("R3 iss_valid", iss_valid, e_valid);
        chk("R5 iss_vlen", iss_vlen, e_vl);
        chk("R11 opcode", iss_opcode, e_op);
        chk("R11 ctype", iss_ctype, e_ct);
        chk("R11 ctrl", iss_ctrl, e_ctrl);
        chk("R11 scalar", iss_scalar, e_sc);
        chk("R11 div", iss_div, e_div);
    endtask

    task automatic idle_clear();
        in_valid = 1'b0; act_vld = '0; vl_we = 1'b0; unit_done = 3'b111;
        tick();
        unit_done = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1337));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R10 reset iss_valid", iss_valid, 3'b000);

        // R10: reset length reaches first issue
        in_valid = 1'b1; in_insn = mk(8'h21, 1, 0, 0, 1, 2, 3, 7); in_scalar = 64'hdead;
        tick();
        chk("R10 reset vlen", iss_vlen, 7'd64);
        idle_clear();

        // R9: invalid slot and unused register never block
        act_addr = '0;
        act_addr[3:0] = 4'd5; act_vld[0] = 1'b0;
        act_addr[7:4] = 4'd7; act_vld[1] = 1'b1;
        in_valid = 1'b1; in_insn = mk(8'h30, 2, 1, 0, 5, 5, 7, 3);
        #2 chk("R9 ready with masked match", in_ready, 1'b1);
        tick();
        idle_clear();

        // R1 / R2: held on conflict, issued unchanged later
        act_vld = '0; act_addr[3:0] = 4'd9; act_vld[0] = 1'b1;
        in_valid = 1'b1; in_insn = mk(8'h44, 3, 2, 0, 9, 1, 2, 1); in_scalar = 64'h1234_5678;
        tick();
        chk("R1 held no issue", iss_valid, 3'b000);
        tick();
        act_vld = '0;
        tick();
        chk("R2 issued unchanged", iss_ctrl, in_insn[31:0]);
        chk("R2 issued to amk", iss_valid, 3'b100);
        idle_clear();

        // R6: write in issue cycle is used; R5: later write does not leak
        in_valid = 1'b1; in_insn = mk(8'h50, 0, 1, 0, 0, 0, 0, 0); vl_we = 1'b1; vl_wdata = 7'd20;
        tick();
        chk("R6 same-cycle vlen", iss_vlen, 7'd20);
        in_valid = 1'b0; vl_wdata = 7'd33;
        tick();
        chk("R5 snapshot kept", iss_vlen, 7'd20);
        vl_we = 1'b0; in_valid = 1'b1; in_insn = mk(8'h51, 0, 0, 0, 0, 0, 0, 0);
        tick();
        chk("R6 new vlen visible", iss_vlen, 7'd33);
        idle_clear();

        // R7: divide blocks everything until its unit is done
        in_valid = 1'b1; in_insn = mk(8'h60, 4, 1, 1, 2, 3, 4, 7);
        tick();
        in_insn = mk(8'h61, 0, 2, 0, 10, 11, 12, 7);
        tick();
        chk("R7 blocked by divide", iss_valid, 3'b000);
        unit_done = 3'b101;
        tick();
        chk("R7 still blocked", iss_valid, 3'b000);
        unit_done = 3'b010;
        tick();
        unit_done = 3'b000;
        tick();
        chk("R7 released", iss_valid, 3'b100);
        idle_clear();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            if (!(in_valid && !last_iss)) begin
                in_valid = ($urandom_range(9, 0) < 7);
                in_insn = mk($urandom_range(255, 0), $urandom_range(7, 0), $urandom_range(3, 0),
                             ($urandom_range(15, 0) == 0), $urandom_range(15, 0),
                             $urandom_range(15, 0), $urandom_range(15, 0), $urandom_range(7, 0));
                in_insn[31:15] = 17'($urandom);
                in_scalar = {$urandom, $urandom};
            end
            for (int i = 0; i < NACT; i++) begin
                act_addr[i*4 +: 4] = 4'($urandom_range(15, 0));
                act_vld[i] = ($urandom_range(5, 0) == 0);
            end
            for (int i = 0; i < 3; i++) unit_done[i] = ($urandom_range(2, 0) == 0);
            vl_we = ($urandom_range(7, 0) == 0);
            vl_wdata = 7'($urandom_range(64, 1));
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule